// File: doc/BRIEF.md
# Multi-Source XOR Parity Engine

This block runs one already-decoded work descriptor against streaming memory data. A 32-bit control word selects the operation. A byte count sets the length. Twelve packed 32-bit words carry up to eight 48-bit source addresses. Two further words give an auxiliary address or fill pattern and the destination address. In parity mode the engine XORs between one and eight source streams, one data word at a time, into one destination stream. It also supports copy, fill and no-op operations.

Memory is seen through two interfaces. The first is a read request port with a valid/ready handshake and one request outstanding at a time. The second is a returned-data beat input. Each finished result word is presented on a write port for a single cycle, together with its destination address. The descriptor closes with a one-cycle done pulse, which carries an error flag and an interrupt request taken from the descriptor.

Top module: `xor_parity_engine`

## Requirements
- R1: The opcode is control bits [31:28]. 0 is no-op, 1 is copy, 2 is fill and 6 is XOR parity. Every other value (3, 4, 5, 7 to 15) ends the descriptor with `err_o`=1 in the done cycle and issues no read and no write.
- R2: In XOR mode the source count N is control bits [25:22]. N=0 or N>8 is an error. Bit 17 (parity output enable) clear is an error. Bit 16 (second-parity enable) set is an error. Every error ends like R1.
- R3: Sources 2k and 2k+1 are unpacked from packed words 3k, 3k+1 and 3k+2, where word j sits at `src_words_i[32j+31:32j]`. Word 3k is the low 32 bits of source 2k. Word 3k+1 is the low 32 bits of source 2k+1. Word 3k+2 bits [15:0] are the high 16 bits of source 2k, and bits [31:16] are the high 16 bits of source 2k+1.
- R4: For beat b (b from 0) the engine requests sources 0 to N-1 in order, at address source+4b. It keeps at most one request outstanding. A request holds valid and a stable address until `rd_req_ready_i` is seen.
- R5: The result of beat b is the XOR of the N returned words. It is written to destination+4b, where destination is {`dst_hi_i`,`dst_lo_i`}. The number of beats is ceil(bytes/4). A byte count of 0 completes with no reads, no writes and no error.
- R6: Copy mode reads only from the auxiliary address {`aux_hi_i`,`aux_lo_i`}+4b and writes each returned word unchanged. The packed source words are ignored.
- R7: Fill mode issues no reads. It writes `aux_lo_i` on every beat, one beat per cycle, with addresses rising by 4.
- R8: A no-op raises `done_o` in the cycle right after start is accepted, with no data. `irq_o` follows control bit 27.
- R9: `done_o` is a one-cycle pulse that follows the last result beat. `irq_o` equals control bit 27 during that pulse and is 0 at all other times.
- R10: After reset, `busy_o`, `rd_req_valid_o`, `wr_valid_o` and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Descriptor valid; accepted when not busy |
| ctrl_i | input | 32 | Control word |
| byte_cnt_i | input | LEN_W | Byte count |
| src_words_i | input | MAX_SRC/2*96 | Packed source address words |
| aux_lo_i | input | 32 | Copy source low word or fill pattern |
| aux_hi_i | input | ADDR_W-32 | Copy source high part |
| dst_lo_i | input | 32 | Destination low word |
| dst_hi_i | input | ADDR_W-32 | Destination high part |
| busy_o | output | 1 | Descriptor in progress |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | ADDR_W | Read byte address |
| rd_data_valid_i | input | 1 | Returned data beat valid |
| rd_data_i | input | DATA_W | Returned data |
| wr_valid_o | output | 1 | Result beat valid |
| wr_addr_o | output | ADDR_W | Result byte address |
| wr_data_o | output | DATA_W | Result data |
| done_o | output | 1 | Descriptor complete pulse |
| err_o | output | 1 | Descriptor rejected, valid with done |
| irq_o | output | 1 | Interrupt request, valid with done |

## Verification
The bench gives every source a different high address half and derives memory data from the full 48-bit address. An unpacker that swapped the two halves of a shared high word would therefore read the wrong locations and produce wrong parity. The bench runs an odd source count with stalled read acceptance and a byte count that is not a multiple of four. A design that dropped a held request, rounded the beat count down or let the last source slot leak in would show a wrong read log or a missing beat. Copy runs with valid-looking packed source words, so an engine that did not switch to the auxiliary address would read the wrong place. Every invalid count, disabled parity output, second-parity request and unsupported opcode must end with the error flag and with no memory traffic at all. A zero-length job must close cleanly without raising the error flag.

// File: rtl/xpe_pkg.sv
package xpe_pkg;
  localparam int OP_LSB  = 28;
  localparam int OP_W    = 4;
  localparam int CNT_LSB = 22;
  localparam int CNT_W   = 4;
  localparam int IOD_BIT = 27;
  localparam int PEN_BIT = 17;
  localparam int QEN_BIT = 16;

  localparam logic [OP_W-1:0] OPC_NOP  = 4'd0;
  localparam logic [OP_W-1:0] OPC_COPY = 4'd1;
  localparam logic [OP_W-1:0] OPC_FILL = 4'd2;
  localparam logic [OP_W-1:0] OPC_XOR  = 4'd6;

  typedef enum logic [1:0] {K_NONE, K_COPY, K_FILL, K_XOR} kind_e;
  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_EMIT, S_FIN} state_e;

  typedef struct packed {
    kind_e             kind;
    logic              err;
    logic              iod;
    logic [CNT_W-1:0]  cnt;
  } dec_t;
endpackage

// File: rtl/xpe_decode.sv
module xpe_decode
  import xpe_pkg::*;
#(
  parameter int MAX_SRC = 8
) (
  input  logic [31:0] ctrl_i,
  output dec_t        dec_o
);
  logic [OP_W-1:0]  opc;
  logic [CNT_W-1:0] cnt;
  logic             unused_bits;

  assign opc = ctrl_i[OP_LSB +: OP_W];
  assign cnt = ctrl_i[CNT_LSB +: CNT_W];
  assign unused_bits = ^{ctrl_i[26], ctrl_i[21:18], ctrl_i[15:0]};

  always_comb begin
    dec_o.kind = K_NONE;
    dec_o.err  = 1'b0;
    dec_o.iod  = ctrl_i[IOD_BIT];
    dec_o.cnt  = cnt;
    case (opc)
      OPC_NOP:  dec_o.kind = K_NONE;
      OPC_COPY: begin
        dec_o.kind = K_COPY;
        dec_o.cnt  = CNT_W'(1);
      end
      OPC_FILL: dec_o.kind = K_FILL;
      OPC_XOR: begin
        dec_o.kind = K_XOR;
        dec_o.err  = (cnt == '0) || (cnt > CNT_W'(MAX_SRC)) ||
                     !ctrl_i[PEN_BIT] || ctrl_i[QEN_BIT];
      end
      default:  dec_o.err = 1'b1;
    endcase
  end
endmodule

// File: rtl/xpe_unpack.sv
module xpe_unpack #(
  parameter int MAX_SRC = 8,
  parameter int ADDR_W  = 48,
  localparam int PK_W   = MAX_SRC / 2 * 3 * 32,
  localparam int HI_W   = ADDR_W - 32
) (
  input  logic [PK_W-1:0]                 words_i,
  output logic [MAX_SRC-1:0][ADDR_W-1:0]  addr_o
);
  for (genvar k = 0; k < MAX_SRC / 2; k++) begin : g_pair
    localparam int W0 = 3 * k * 32;
    localparam int W1 = (3 * k + 1) * 32;
    localparam int W2 = (3 * k + 2) * 32;
    assign addr_o[2*k]   = {words_i[W2 +: HI_W],      words_i[W0 +: 32]};
    assign addr_o[2*k+1] = {words_i[W2 + 16 +: HI_W], words_i[W1 +: 32]};
  end
endmodule

// File: rtl/xpe_accum.sv
module xpe_accum #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              fold_i,
  input  logic              first_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] acc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_o <= '0;
    else if (load_i) acc_o <= load_val_i;
    else if (fold_i) acc_o <= first_i ? data_i : (acc_o ^ data_i);
  end
endmodule

// File: rtl/xor_parity_engine.sv
module xor_parity_engine
  import xpe_pkg::*;
#(
  parameter int MAX_SRC = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 48,
  parameter int LEN_W   = 32,
  localparam int PK_W       = MAX_SRC / 2 * 3 * 32,
  localparam int HI_W       = ADDR_W - 32,
  localparam int BEAT_BYTES = DATA_W / 8,
  localparam int BEAT_SH    = $clog2(BEAT_BYTES),
  localparam int SRC_IW     = $clog2(MAX_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       ctrl_i,
  input  logic [LEN_W-1:0]  byte_cnt_i,
  input  logic [PK_W-1:0]   src_words_i,
  input  logic [31:0]       aux_lo_i,
  input  logic [HI_W-1:0]   aux_hi_i,
  input  logic [31:0]       dst_lo_i,
  input  logic [HI_W-1:0]   dst_hi_i,
  output logic              busy_o,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_data_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              done_o,
  output logic              err_o,
  output logic              irq_o
);
  dec_t                          dec;
  logic [MAX_SRC-1:0][ADDR_W-1:0] unpacked;
  state_e                        state_q;
  kind_e                         kind_q;
  logic                          err_q, iod_q;
  logic [CNT_W-1:0]              cnt_q;
  logic [SRC_IW-1:0]             src_idx_q;
  logic [LEN_W-1:0]              beat_q, nbeats_q;
  logic [MAX_SRC-1:0][ADDR_W-1:0] src_q;
  logic [ADDR_W-1:0]             dst_q, off;
  logic [LEN_W:0]                bsum;
  logic [LEN_W-1:0]              nbeats;
  logic                          accept, last_src, last_beat, fold;

  xpe_decode #(.MAX_SRC(MAX_SRC)) u_dec (.ctrl_i(ctrl_i), .dec_o(dec));

  xpe_unpack #(.MAX_SRC(MAX_SRC), .ADDR_W(ADDR_W)) u_unp (
    .words_i(src_words_i), .addr_o(unpacked));

  assign accept    = start_i && (state_q == S_IDLE);
  assign bsum      = {1'b0, byte_cnt_i} + (LEN_W+1)'(BEAT_BYTES - 1);
  assign nbeats    = LEN_W'(bsum >> BEAT_SH);
  assign off       = ADDR_W'(beat_q) << BEAT_SH;
  assign last_src  = (CNT_W'(src_idx_q) + CNT_W'(1)) == cnt_q;
  assign last_beat = beat_q == (nbeats_q - LEN_W'(1));
  assign fold      = (state_q == S_WAIT) && rd_data_valid_i;

  xpe_accum #(.DATA_W(DATA_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(accept), .load_val_i(DATA_W'(aux_lo_i)),
    .fold_i(fold), .first_i(src_idx_q == '0),
    .data_i(rd_data_i), .acc_o(wr_data_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      kind_q    <= K_NONE;
      err_q     <= 1'b0;
      iod_q     <= 1'b0;
      cnt_q     <= '0;
      src_idx_q <= '0;
      beat_q    <= '0;
      nbeats_q  <= '0;
      src_q     <= '0;
      dst_q     <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          kind_q    <= dec.kind;
          err_q     <= dec.err;
          iod_q     <= dec.iod;
          cnt_q     <= dec.cnt;
          src_idx_q <= '0;
          beat_q    <= '0;
          nbeats_q  <= nbeats;
          dst_q     <= {dst_hi_i, dst_lo_i};
          for (int i = 0; i < MAX_SRC; i++)
            src_q[i] <= (dec.kind == K_COPY && i == 0) ? {aux_hi_i, aux_lo_i} : unpacked[i];
          if (dec.err || dec.kind == K_NONE || nbeats == '0) state_q <= S_FIN;
          else if (dec.kind == K_FILL)                        state_q <= S_EMIT;
          else                                                state_q <= S_REQ;
        end
        S_REQ: if (rd_req_ready_i) state_q <= S_WAIT;
        S_WAIT: if (rd_data_valid_i) begin
          if (last_src) state_q <= S_EMIT;
          else begin
            src_idx_q <= src_idx_q + SRC_IW'(1);
            state_q   <= S_REQ;
          end
        end
        S_EMIT: begin
          beat_q    <= beat_q + LEN_W'(1);
          src_idx_q <= '0;
          if (last_beat)              state_q <= S_FIN;
          else if (kind_q == K_FILL)  state_q <= S_EMIT;
          else                        state_q <= S_REQ;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o         = state_q != S_IDLE;
  assign rd_req_valid_o = state_q == S_REQ;
  assign rd_addr_o      = src_q[src_idx_q] + off;
  assign wr_valid_o     = state_q == S_EMIT;
  assign wr_addr_o      = dst_q + off;
  assign done_o         = state_q == S_FIN;
  assign err_o          = done_o && err_q;
  assign irq_o          = done_o && iod_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_addr_o)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_ERR_IN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R1
  AST_NOP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && ctrl_i[OP_LSB +: OP_W] == OPC_NOP |=> done_o && !err_o); // R8
  AST_FILL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && $past(wr_valid_o) |-> wr_addr_o == $past(wr_addr_o) + ADDR_W'(BEAT_BYTES)); // R7
endmodule

// File: tb/sim_xor_parity_engine.sv
module sim_xor_parity_engine;
  localparam int CLK_PERIOD = 10;
  localparam int PK_W = 384;

  logic clk = 0, rst_n = 0;
  logic start_i = 0;
  logic [31:0] ctrl_i = 0, byte_cnt_i = 0, aux_lo_i = 0, dst_lo_i = 0;
  logic [15:0] aux_hi_i = 0, dst_hi_i = 0;
  logic [PK_W-1:0] src_words_i = '0;
  logic busy_o, rd_req_valid_o, rd_req_ready_i = 1, rd_data_valid_i = 0;
  logic [47:0] rd_addr_o, wr_addr_o;
  logic [31:0] rd_data_i = 0, wr_data_o;
  logic wr_valid_o, done_o, err_o, irq_o;

  xor_parity_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .ctrl_i(ctrl_i),
    .byte_cnt_i(byte_cnt_i), .src_words_i(src_words_i), .aux_lo_i(aux_lo_i),
    .aux_hi_i(aux_hi_i), .dst_lo_i(dst_lo_i), .dst_hi_i(dst_hi_i), .busy_o(busy_o),
    .rd_req_valid_o(rd_req_valid_o), .rd_req_ready_i(rd_req_ready_i), .rd_addr_o(rd_addr_o),
    .rd_data_valid_i(rd_data_valid_i), .rd_data_i(rd_data_i), .wr_valid_o(wr_valid_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .done_o(done_o), .err_o(err_o), .irq_o(irq_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [47:0] sa [8];
  logic [47:0] rd_log [128];
  logic [47:0] wr_alog [64];
  logic [31:0] wr_dlog [64];
  int rd_n = 0, wr_n = 0;
  bit done_seen = 0, err_seen = 0, irq_seen = 0, first_done = 0, stall_mode = 0;
  bit pend = 0;
  logic [47:0] pend_a = 0;

  function automatic logic [31:0] mem_rd(logic [47:0] a);
    return a[31:0] ^ {a[47:32], a[47:32]} ^ 32'h3C5A96E1;
  endfunction

  function automatic logic [PK_W-1:0] pack_src(logic [47:0] s [8]);
    logic [PK_W-1:0] w = '0;
    for (int k = 0; k < 4; k++) begin
      w[(3*k)*32 +: 32]   = s[2*k][31:0];
      w[(3*k+1)*32 +: 32] = s[2*k+1][31:0];
      w[(3*k+2)*32 +: 32] = {s[2*k+1][47:32], s[2*k][47:32]};
    end
    return w;
  endfunction

  function automatic logic [31:0] mk_ctrl(int op, int cnt, bit p, bit q, bit iod);
    return (32'(op) << 28) | (32'(iod) << 27) | (32'(cnt) << 22) | (32'(p) << 17) | (32'(q) << 16);
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model and monitor
  always @(negedge clk) begin
    rd_data_valid_i = pend;
    rd_data_i = pend ? mem_rd(pend_a) : 32'h0;
    rd_req_ready_i = stall_mode ? ~rd_req_ready_i : 1'b1;
    pend = rd_req_valid_o && rd_req_ready_i;
    pend_a = rd_addr_o;
    if (pend && rd_n < 128) begin rd_log[rd_n] = rd_addr_o; rd_n++; end
    if (wr_valid_o && wr_n < 64) begin wr_alog[wr_n] = wr_addr_o; wr_dlog[wr_n] = wr_data_o; wr_n++; end
    if (done_o) begin done_seen = 1; err_seen = err_o; irq_seen = irq_o; end
  end

  task automatic run_desc(logic [31:0] ctrl, logic [31:0] nbytes, bit stall);
    int waited;
    @(negedge clk);
    rd_n = 0; wr_n = 0; done_seen = 0; err_seen = 0; irq_seen = 0;
    stall_mode = stall;
    ctrl_i = ctrl; byte_cnt_i = nbytes; src_words_i = pack_src(sa); start_i = 1;
    @(negedge clk);
    start_i = 0;
    first_done = done_o;
    waited = 0;
    while (!done_seen && waited < 3000) begin @(negedge clk); waited++; end
    if (!done_seen) chk("R9", "timeout waiting done", 0, 1);
    @(negedge clk);
    stall_mode = 0;
  endtask

  task automatic set_srcs();
    for (int i = 0; i < 8; i++)
      sa[i] = {16'h0A00 + 16'(i * 257), 32'h4000_0000 + 32'(i) * 32'h0001_0100};
  endtask

  // ns = 0 means fill (no reads, pattern pat)
  task automatic expect_stream(string req, int ns, int nb, logic [31:0] pat, logic [47:0] dst);
    chk(req, "read count", rd_n, ns * nb);
    chk(req, "write count", wr_n, nb);
    for (int b = 0; b < nb; b++) begin
      logic [31:0] x = (ns == 0) ? pat : 32'h0;
      for (int s = 0; s < ns; s++) begin
        if (b * ns + s < rd_n) chk("R4", "read addr order", rd_log[b*ns+s], sa[s] + 48'(4*b));
        x ^= mem_rd(sa[s] + 48'(4*b));
      end
      if (b < wr_n) begin
        chk(req, "write addr", wr_alog[b], dst + 48'(4*b));
        chk(req, "write data", wr_dlog[b], x);
      end
    end
    chk("R1", "no error", err_seen, 0);
  endtask

  task automatic t_reset();
    chk("R10", "busy after reset", busy_o, 0);
    chk("R10", "rd valid after reset", rd_req_valid_o, 0);
    chk("R10", "wr valid after reset", wr_valid_o, 0);
    chk("R10", "done after reset", done_o, 0);
  endtask

  task automatic t_xor(int n, int nbytes, bit stall, bit iod);
    set_srcs();
    dst_lo_i = 32'h8000_0040; dst_hi_i = 16'h00BE;
    run_desc(mk_ctrl(6, n, 1, 0, iod), 32'(nbytes), stall);
    expect_stream("R5", n, (nbytes + 3) / 4, 0, {16'h00BE, 32'h8000_0040});
    chk("R9", "irq follows bit27", irq_seen, iod);
    chk("R3", "first read hits source 0", rd_log[0], sa[0]);
  endtask

  task automatic t_copy();
    set_srcs();
    aux_lo_i = 32'h1234_5600; aux_hi_i = 16'h7777;
    dst_lo_i = 32'h0000_1000; dst_hi_i = 16'h0003;
    run_desc(mk_ctrl(1, 0, 0, 0, 0), 32'd8, 0);
    sa[0] = {16'h7777, 32'h1234_5600};
    expect_stream("R6", 1, 2, 0, {16'h0003, 32'h0000_1000});
  endtask

  task automatic t_fill();
    aux_lo_i = 32'hDEAD_BEEF;
    dst_lo_i = 32'h0000_2000; dst_hi_i = 16'h0001;
    run_desc(mk_ctrl(2, 0, 0, 0, 1), 32'd16, 0);
    expect_stream("R7", 0, 4, 32'hDEAD_BEEF, {16'h0001, 32'h0000_2000});
    chk("R9", "fill irq", irq_seen, 1);
  endtask

  task automatic t_nop(bit iod);
    run_desc(mk_ctrl(0, 0, 0, 0, iod), 32'd64, 0);
    chk("R8", "done one cycle after start", first_done, 1);
    chk("R8", "nop irq", irq_seen, iod);
    chk("R8", "nop no reads", rd_n, 0);
    chk("R8", "nop no writes", wr_n, 0);
    chk("R8", "nop no error", err_seen, 0);
  endtask

  task automatic t_err(string req, logic [31:0] ctrl);
    set_srcs();
    run_desc(ctrl, 32'd12, 0);
    chk(req, "error flagged", err_seen, 1);
    chk(req, "error no reads", rd_n, 0);
    chk(req, "error no writes", wr_n, 0);
  endtask

  task automatic t_zero_len();
    set_srcs();
    run_desc(mk_ctrl(6, 2, 1, 0, 0), 32'd0, 0);
    chk("R5", "zero length done", done_seen, 1);
    chk("R5", "zero length no error", err_seen, 0);
    chk("R5", "zero length no reads", rd_n, 0);
    chk("R5", "zero length no writes", wr_n, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_xor(8, 12, 0, 1);   // R3 all pairs
    t_xor(3, 10, 1, 0);   // R4 stalled, odd count, rounded length
    t_xor(1, 4, 0, 1);
    t_copy();
    t_fill();
    t_nop(1);
    t_nop(0);
    t_err("R2", mk_ctrl(6, 0, 1, 0, 0));
    t_err("R2", mk_ctrl(6, 9, 1, 0, 0));
    t_err("R2", mk_ctrl(6, 2, 1, 1, 0));
    t_err("R2", mk_ctrl(6, 2, 0, 0, 0));
    t_err("R1", mk_ctrl(5, 2, 1, 0, 0));
    t_err("R1", mk_ctrl(3, 1, 0, 0, 0));
    t_err("R1", mk_ctrl(15, 1, 1, 0, 1));
    t_zero_len();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule